// File: doc/BRIEF.md
# Command Start and Completion Sequencer

This block owns the start bit of a command/response shared-buffer interface. The host programs a command address and length and a response address and length, fills the shared byte buffer, and then writes 1 to the start bit. The sequencer captures the two regions as buffer offsets and checks that both fit inside the buffer. It then issues a request to an external execution engine and streams the command bytes to it in order.

While the engine works, the sequencer zeroes every byte of the shared buffer, one byte per cycle. It then accepts the engine's response stream and places the bytes at the response offset. Only after the last response byte has been written does it clear the start bit. A region that does not fit is refused without any engine request: an error flag is raised and the start bit drops at once.

The buffer itself sits outside the block. The sequencer drives its single byte-wide port with registered write enable, address and data, and takes read data one cycle after the address. Host byte writes to the buffer pass through the sequencer, so they can be held off while a command is in flight.

Top module: `cmd_seq`

## Requirements
- R1: After reset, start and error read 0, both host ports are ready, no engine request or buffer write is active, both lengths equal the buffer size (0xF80) and both addresses equal the buffer base address.
- R2: A register write to offset 0x4C with bit 0 set, made while start is clear, sets start and produces exactly one engine request.
- R3: A write to offset 0x4C with bit 0 clear, or any write there while start is set, changes nothing and produces no extra engine request.
- R4: Each region's offset is its address minus the buffer base, taken modulo 2^32. The region is refused if the offset exceeds 0xF80 or if offset plus length exceeds 0xF80. A region that ends exactly at 0xF80 is accepted.
- R5: When either region is refused, the error flag is set and start is cleared with no engine request and no change to the buffer. The error flag is cleared by the next accepted start.
- R6: After the request handshake, the bytes at buffer[cmd_offset] through buffer[cmd_offset+len-1] are sent to the engine in ascending order. A zero-length command sends none.
- R7: Before any response byte is stored, every byte of the buffer is written to zero, so no earlier content remains readable.
- R8: Response bytes are written from the response offset upward, one per engine byte, up to the programmed response length. Bytes the engine did not supply stay zero, bytes beyond the length are dropped, and the engine marks its final byte with a last flag.
- R9: Start returns to 0 only after the final response byte has been written to the buffer.
- R10: A write to offset 0x48 is always accepted and has no effect on a running command.
- R11: While start is set, host buffer writes and writes to the length and address registers (0x58 command length, 0x5C command address, 0x64 response length, 0x68 response address) are held off with ready low and take no effect. Writes to 0x48 and 0x4C are always accepted.
- R12: A host buffer byte write accepted in the same cycle as an accepted start is part of the command that start launches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_valid | input | 1 | Host register write valid |
| hw_addr | input | RAW | Host register byte offset |
| hw_data | input | DW | Host register write data |
| hw_ready | output | 1 | Host register write accepted |
| hb_valid | input | 1 | Host buffer byte write valid |
| hb_addr | input | AW | Host buffer byte index |
| hb_data | input | 8 | Host buffer byte data |
| hb_ready | output | 1 | Host buffer write accepted |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | AW | Buffer byte address |
| buf_wdata | output | 8 | Buffer write data |
| buf_rdata | input | 8 | Buffer read data, one cycle after address |
| eng_req_valid | output | 1 | Engine request valid |
| eng_req_ready | input | 1 | Engine request ready |
| eng_cmd_len | output | CW | Command length of the request |
| eng_rsp_len | output | CW | Response length of the request |
| eng_cmd_valid | output | 1 | Command byte valid |
| eng_cmd_ready | input | 1 | Command byte ready |
| eng_cmd_data | output | 8 | Command byte |
| eng_rsp_valid | input | 1 | Response byte valid |
| eng_rsp_ready | output | 1 | Response byte ready |
| eng_rsp_data | input | 8 | Response byte |
| eng_rsp_last | input | 1 | Final response byte |
| start_o | output | 1 | Start bit |
| err_o | output | 1 | Region-check error flag |

## Verification
Two host actions can land in the same cycle as the start write. One is a buffer byte write. The bench issues it together with the start write and expects that byte to arrive in the engine's command stream (R12). The other is a further host write made while the command runs. Length-register and buffer writes are tried at the same time, and both ready signals must be low. Cancel and a repeated start are then written, and both must be accepted. The run must still produce exactly one request and a buffer image in which the held-off byte never appears. The next command shows that the held-off length write did not change the command length.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
  localparam logic [11:0] OFS_CANCEL   = 12'h048;
  localparam logic [11:0] OFS_START    = 12'h04C;
  localparam logic [11:0] OFS_CMD_SIZE = 12'h058;
  localparam logic [11:0] OFS_CMD_ADDR = 12'h05C;
  localparam logic [11:0] OFS_RSP_SIZE = 12'h064;
  localparam logic [11:0] OFS_RSP_ADDR = 12'h068;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHECK, ST_REQ, ST_CMD_RD, ST_CMD_WT, ST_CMD_LD,
    ST_CMD_TX, ST_SCRUB, ST_RSP, ST_DONE
  } seq_state_t;
endpackage

// File: rtl/cmd_seq_regs.sv
module cmd_seq_regs import cmd_seq_pkg::*; #(
  parameter int DW = 32,
  parameter int RAW = 12,
  parameter int DEPTH = 3968,
  parameter logic [DW-1:0] BASE = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy,
  input  logic          hw_valid,
  input  logic [RAW-1:0] hw_addr,
  input  logic [DW-1:0] hw_data,
  output logic          hw_ready,
  output logic          start_req,
  output logic [DW-1:0] cmd_size,
  output logic [DW-1:0] cmd_addr,
  output logic [DW-1:0] rsp_size,
  output logic [DW-1:0] rsp_addr
);
  localparam logic [DW-1:0] SIZE_RST = DW'(DEPTH);

  logic hit_start, hit_cancel;
  assign hit_start  = (hw_addr == RAW'(OFS_START));
  assign hit_cancel = (hw_addr == RAW'(OFS_CANCEL));
  assign hw_ready   = !busy || hit_start || hit_cancel;
  assign start_req  = hw_valid && hit_start && hw_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_size <= SIZE_RST;
      cmd_addr <= BASE;
      rsp_size <= SIZE_RST;
      rsp_addr <= BASE;
    end else if (hw_valid && !busy) begin
      case (hw_addr)
        RAW'(OFS_CMD_SIZE): cmd_size <= hw_data;
        RAW'(OFS_CMD_ADDR): cmd_addr <= hw_data;
        RAW'(OFS_RSP_SIZE): rsp_size <= hw_data;
        RAW'(OFS_RSP_ADDR): rsp_addr <= hw_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cmd_seq_bounds.sv
module cmd_seq_bounds #(
  parameter int DW = 32,
  parameter int DEPTH = 3968,
  parameter int AW = 12,
  parameter int CW = 12,
  parameter logic [DW-1:0] BASE = '0
) (
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] size,
  output logic [AW-1:0] off,
  output logic [CW-1:0] len,
  output logic          ok
);
  localparam logic [DW:0] LIM = (DW+1)'(DEPTH);

  logic [DW-1:0] full_off;
  logic [DW:0]   span_end;

  assign full_off = addr - BASE;
  assign span_end = {1'b0, full_off} + {1'b0, size};
  assign ok  = ({1'b0, full_off} <= LIM) && (span_end <= LIM);
  assign off = AW'(full_off);
  assign len = CW'(size);
endmodule

// File: rtl/cmd_seq.sv
module cmd_seq import cmd_seq_pkg::*; #(
  parameter int DEPTH = 3968,
  parameter int DW = 32,
  parameter int RAW = 12,
  parameter logic [DW-1:0] BASE = 32'hFED4_0080,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hw_valid,
  input  logic [RAW-1:0] hw_addr,
  input  logic [DW-1:0]  hw_data,
  output logic           hw_ready,
  input  logic           hb_valid,
  input  logic [AW-1:0]  hb_addr,
  input  logic [7:0]     hb_data,
  output logic           hb_ready,
  output logic           buf_we,
  output logic [AW-1:0]  buf_addr,
  output logic [7:0]     buf_wdata,
  input  logic [7:0]     buf_rdata,
  output logic           eng_req_valid,
  input  logic           eng_req_ready,
  output logic [CW-1:0]  eng_cmd_len,
  output logic [CW-1:0]  eng_rsp_len,
  output logic           eng_cmd_valid,
  input  logic           eng_cmd_ready,
  output logic [7:0]     eng_cmd_data,
  input  logic           eng_rsp_valid,
  output logic           eng_rsp_ready,
  input  logic [7:0]     eng_rsp_data,
  input  logic           eng_rsp_last,
  output logic           start_o,
  output logic           err_o
);
  localparam logic [CW-1:0] SCRUB_LAST = CW'(DEPTH - 1);
  localparam logic [AW:0]   BUF_LIM    = (AW+1)'(DEPTH);

  seq_state_t st;
  logic busy, start_req;
  logic [DW-1:0] reg_cmd_size, reg_cmd_addr, reg_rsp_size, reg_rsp_addr;

  assign busy = (st != ST_IDLE);

  cmd_seq_regs #(.DW(DW), .RAW(RAW), .DEPTH(DEPTH), .BASE(BASE)) u_regs (
    .clk(clk), .rst(rst), .busy(busy),
    .hw_valid(hw_valid), .hw_addr(hw_addr), .hw_data(hw_data),
    .hw_ready(hw_ready), .start_req(start_req),
    .cmd_size(reg_cmd_size), .cmd_addr(reg_cmd_addr),
    .rsp_size(reg_rsp_size), .rsp_addr(reg_rsp_addr)
  );

  // index 0: command region, index 1: response region
  logic [DW-1:0] rg_addr [2];
  logic [DW-1:0] rg_size [2];
  logic [AW-1:0] rg_off  [2];
  logic [CW-1:0] rg_len  [2];
  logic          rg_ok   [2];

  assign rg_addr[0] = reg_cmd_addr;
  assign rg_size[0] = reg_cmd_size;
  assign rg_addr[1] = reg_rsp_addr;
  assign rg_size[1] = reg_rsp_size;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_rng
      cmd_seq_bounds #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .CW(CW), .BASE(BASE)) u_rng (
        .addr(rg_addr[g]), .size(rg_size[g]),
        .off(rg_off[g]), .len(rg_len[g]), .ok(rg_ok[g])
      );
    end
  endgenerate

  logic [AW-1:0] coff, roff;
  logic [CW-1:0] csz, rsz, idx, ridx;
  logic          fits;
  logic          hb_in_range;

  assign hb_ready      = !busy;
  assign hb_in_range   = ({1'b0, hb_addr} < BUF_LIM);
  assign eng_rsp_ready = (st == ST_RSP);
  assign eng_cmd_len   = csz;
  assign eng_rsp_len   = rsz;

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      start_o       <= 1'b0;
      err_o         <= 1'b0;
      buf_we        <= 1'b0;
      buf_addr      <= '0;
      buf_wdata     <= '0;
      eng_req_valid <= 1'b0;
      eng_cmd_valid <= 1'b0;
      eng_cmd_data  <= '0;
      coff          <= '0;
      roff          <= '0;
      csz           <= '0;
      rsz           <= '0;
      idx           <= '0;
      ridx          <= '0;
      fits          <= 1'b0;
    end else begin
      buf_we <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (hb_valid && hb_in_range) begin
            buf_we    <= 1'b1;
            buf_addr  <= hb_addr;
            buf_wdata <= hb_data;
          end
          if (start_req) begin
            start_o <= 1'b1;
            err_o   <= 1'b0;
            coff    <= rg_off[0];
            csz     <= rg_len[0];
            roff    <= rg_off[1];
            rsz     <= rg_len[1];
            fits    <= rg_ok[0] && rg_ok[1];
            st      <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (!fits) begin
            err_o   <= 1'b1;
            start_o <= 1'b0;
            st      <= ST_IDLE;
          end else begin
            eng_req_valid <= 1'b1;
            st            <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (eng_req_ready) begin
            eng_req_valid <= 1'b0;
            idx           <= '0;
            st            <= (csz == '0) ? ST_SCRUB : ST_CMD_RD;
          end
        end
        ST_CMD_RD: begin
          buf_addr <= coff + AW'(idx);
          st       <= ST_CMD_WT;
        end
        ST_CMD_WT: st <= ST_CMD_LD;
        ST_CMD_LD: begin
          eng_cmd_data  <= buf_rdata;
          eng_cmd_valid <= 1'b1;
          st            <= ST_CMD_TX;
        end
        ST_CMD_TX: begin
          if (eng_cmd_ready) begin
            eng_cmd_valid <= 1'b0;
            if (idx == csz - 1'b1) begin
              idx <= '0;
              st  <= ST_SCRUB;
            end else begin
              idx <= idx + 1'b1;
              st  <= ST_CMD_RD;
            end
          end
        end
        ST_SCRUB: begin
          buf_we    <= 1'b1;
          buf_addr  <= AW'(idx);
          buf_wdata <= '0;
          if (idx == SCRUB_LAST) begin
            idx  <= '0;
            ridx <= '0;
            st   <= ST_RSP;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_RSP: begin
          if (eng_rsp_valid) begin
            if (ridx < rsz) begin
              buf_we    <= 1'b1;
              buf_addr  <= roff + AW'(ridx);
              buf_wdata <= eng_rsp_data;
              ridx      <= ridx + 1'b1;
            end
            if (eng_rsp_last) st <= ST_DONE;
          end
        end
        ST_DONE: begin
          start_o <= 1'b0;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_seq_chk.sv
module cmd_seq_chk import cmd_seq_pkg::*; #(
  parameter int RAW = 12
) (
  input logic           clk,
  input logic           rst,
  input logic           hw_valid,
  input logic [RAW-1:0] hw_addr,
  input logic           start_bit,
  input logic           hb_ready,
  input logic           start_o,
  input logic           err_o,
  input logic           eng_req_valid,
  input logic           eng_cmd_valid,
  input logic           eng_rsp_valid,
  input logic           eng_rsp_ready,
  input logic           eng_rsp_last
);
  AST_START_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(start_o) |-> $past(hw_valid && hw_addr == RAW'(OFS_START) && start_bit)); // R2
  AST_STALL_BUSY: assert property (@(posedge clk) disable iff (rst)
    start_o |-> !hb_ready); // R11
  AST_REQ_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    eng_req_valid |-> (start_o && !err_o)); // R5
  AST_ERR_DROPS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> !start_o); // R5
  AST_CMD_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    eng_cmd_valid |-> start_o); // R6
  AST_HOLD_TO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (eng_rsp_valid && eng_rsp_ready && eng_rsp_last) |=> start_o); // R9
endmodule

bind cmd_seq cmd_seq_chk #(.RAW(RAW)) i_chk (
  .clk(clk), .rst(rst), .hw_valid(hw_valid), .hw_addr(hw_addr),
  .start_bit(hw_data[0]), .hb_ready(hb_ready), .start_o(start_o),
  .err_o(err_o), .eng_req_valid(eng_req_valid), .eng_cmd_valid(eng_cmd_valid),
  .eng_rsp_valid(eng_rsp_valid), .eng_rsp_ready(eng_rsp_ready),
  .eng_rsp_last(eng_rsp_last)
);

// File: tb/test_cmd_seq.sv
module test_cmd_seq;
  import cmd_seq_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 3968;
  localparam logic [31:0] BASE = 32'hFED4_0080;

  logic clk = 1'b0, rst = 1'b1;
  logic hw_valid = 1'b0; logic [11:0] hw_addr = '0; logic [31:0] hw_data = '0;
  logic hb_valid = 1'b0; logic [11:0] hb_addr = '0; logic [7:0] hb_data = '0;
  logic hw_ready, hb_ready, buf_we;
  logic [11:0] buf_addr; logic [7:0] buf_wdata; logic [7:0] buf_rdata = '0;
  logic eng_req_valid; logic eng_req_ready = 1'b1;
  logic [11:0] eng_cmd_len, eng_rsp_len;
  logic eng_cmd_valid; logic eng_cmd_ready = 1'b1; logic [7:0] eng_cmd_data;
  logic eng_rsp_valid = 1'b0, eng_rsp_last = 1'b0; logic eng_rsp_ready;
  logic [7:0] eng_rsp_data = '0;
  logic start_o, err_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_seq i_cmd_seq (
    .clk(clk), .rst(rst), .hw_valid(hw_valid), .hw_addr(hw_addr), .hw_data(hw_data),
    .hw_ready(hw_ready), .hb_valid(hb_valid), .hb_addr(hb_addr), .hb_data(hb_data),
    .hb_ready(hb_ready), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .eng_req_valid(eng_req_valid), .eng_req_ready(eng_req_ready),
    .eng_cmd_len(eng_cmd_len), .eng_rsp_len(eng_rsp_len), .eng_cmd_valid(eng_cmd_valid),
    .eng_cmd_ready(eng_cmd_ready), .eng_cmd_data(eng_cmd_data),
    .eng_rsp_valid(eng_rsp_valid), .eng_rsp_ready(eng_rsp_ready),
    .eng_rsp_data(eng_rsp_data), .eng_rsp_last(eng_rsp_last),
    .start_o(start_o), .err_o(err_o)
  );

  // external shared buffer, synchronous read
  logic [7:0] mem [DEPTH];
  logic [7:0] exp_mem [DEPTH];
  always @(posedge clk) begin
    if (buf_we) mem[buf_addr] <= buf_wdata;
    buf_rdata <= mem[buf_addr];
  end

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  // behavioural engine model
  int req_cnt = 0;
  bit req_seen = 0;
  int exp_len = 0;
  bit pop_pend = 0;
  logic [7:0] cmd_got[$];
  logic [7:0] rsp_src[$];

  initial begin
    forever begin
      @(negedge clk); #2;
      if (pop_pend) begin void'(rsp_src.pop_front()); pop_pend = 0; end
      if (eng_req_valid && eng_req_ready) begin
        req_cnt++; req_seen = 1; exp_len = int'(eng_cmd_len);
      end
      if (eng_cmd_valid && eng_cmd_ready) cmd_got.push_back(eng_cmd_data);
      if (req_seen && cmd_got.size() == exp_len && rsp_src.size() > 0) begin
        eng_rsp_valid = 1'b1; eng_rsp_data = rsp_src[0];
        eng_rsp_last = (rsp_src.size() == 1);
      end else begin
        eng_rsp_valid = 1'b0; eng_rsp_last = 1'b0;
      end
      if (eng_rsp_valid && eng_rsp_ready) pop_pend = 1;
    end
  end

  // per-clock comparison of the stall model: busy exactly while start is set (R11)
  initial begin
    forever begin
      @(negedge clk); #1;
      if (!rst) chk("R11 hb_ready vs start", hb_ready, !start_o);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_up();
  end

  task automatic eng_clear();
    cmd_got.delete(); rsp_src.delete(); req_seen = 0; pop_pend = 0;
  endtask

  task automatic clear_exp();
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = '0;
  endtask

  task automatic hw_wr(input logic [11:0] a, input logic [31:0] d);
    hw_valid = 1'b1; hw_addr = a; hw_data = d;
    @(negedge clk);
    hw_valid = 1'b0;
  endtask

  task automatic hb_wr(input int a, input logic [7:0] d);
    hb_valid = 1'b1; hb_addr = 12'(a); hb_data = d;
    @(negedge clk);
    hb_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (start_o) begin
      @(negedge clk); n++;
      if (n > 40000) begin chk({req, " timeout"}, 1, 0); break; end
    end
  endtask

  task automatic chk_mem(input string req);
    int bad = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(req, bad, 0);
  endtask

  initial begin
    int req_before;
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 start in reset", start_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 start after reset", start_o, 0);
    chk("R1 err after reset", err_o, 0);
    chk("R1 hw_ready", hw_ready, 1);
    chk("R1 hb_ready", hb_ready, 1);
    chk("R1 no request", eng_req_valid, 0);
    chk("R1 no buffer write", buf_we, 0);

    // T1: default regions cover the whole buffer (R1 defaults, R6 order)
    eng_clear(); clear_exp();
    hb_wr(0, 8'h11); hb_wr(1, 8'h22); hb_wr(2, 8'h33); hb_wr(3, 8'h44);
    hb_wr(DEPTH-1, 8'h5A);
    rsp_src.push_back(8'hC1); rsp_src.push_back(8'hC2);
    hw_wr(OFS_START, 32'h1);
    chk("R2 start set", start_o, 1);
    wait_done("R9 default run");
    chk("R2 one request", req_cnt, 1);
    chk("R1 default cmd length", cmd_got.size(), DEPTH);
    chk("R6 byte 0", cmd_got[0], 8'h11);
    chk("R6 byte 3", cmd_got[3], 8'h44);
    chk("R6 last byte", cmd_got[DEPTH-1], 8'h5A);
    exp_mem[0] = 8'hC1; exp_mem[1] = 8'hC2;
    chk_mem("R8 default response image");
    chk("R5 err clear", err_o, 0);

    // T2: placed regions, stale data, coincident write, stalls, cancel, restart
    eng_clear(); clear_exp();
    hw_wr(OFS_CMD_ADDR, BASE + 32'h20); hw_wr(OFS_CMD_SIZE, 32'd4);
    hw_wr(OFS_RSP_ADDR, BASE + 32'h100); hw_wr(OFS_RSP_SIZE, 32'd6);
    hb_wr(32'h20, 8'hA0); hb_wr(32'h21, 8'hA1); hb_wr(32'h22, 8'hA2);
    hb_wr(32'h800, 8'h77);
    for (int k = 0; k < 4; k++) rsp_src.push_back(8'hD0 + 8'(k));
    req_before = req_cnt;
    hb_valid = 1'b1; hb_addr = 12'h023; hb_data = 8'hA3;   // R12 same cycle as start
    hw_valid = 1'b1; hw_addr = OFS_START; hw_data = 32'h1;
    @(negedge clk);
    hb_valid = 1'b1; hb_addr = 12'h300; hb_data = 8'hEE;
    hw_valid = 1'b1; hw_addr = OFS_CMD_SIZE; hw_data = 32'd5;
    #1;
    chk("R11 hb write held", hb_ready, 0);
    chk("R11 size write held", hw_ready, 0);
    @(negedge clk);
    hb_valid = 1'b0;
    hw_addr = OFS_CANCEL; hw_data = 32'h1;
    #1 chk("R10 cancel accepted", hw_ready, 1);
    @(negedge clk);
    hw_addr = OFS_START; hw_data = 32'h1;
    #1 chk("R3 restart accepted", hw_ready, 1);
    @(negedge clk);
    hw_valid = 1'b0;
    chk("R10 run continues", start_o, 1);
    wait_done("R9 placed run");
    chk("R3 single request", req_cnt - req_before, 1);
    chk("R6 cmd length", cmd_got.size(), 4);
    chk("R6 cmd byte 0", cmd_got[0], 8'hA0);
    chk("R6 cmd byte 2", cmd_got[2], 8'hA2);
    chk("R12 coincident byte", cmd_got[3], 8'hA3);
    for (int k = 0; k < 4; k++) exp_mem[32'h100 + k] = 8'hD0 + 8'(k);
    chk_mem("R7 R8 R9 R11 image at start fall");

    // T3: response ends exactly at the limit, engine overruns the length
    eng_clear(); clear_exp();
    hw_wr(OFS_RSP_ADDR, BASE + 32'hF7E); hw_wr(OFS_RSP_SIZE, 32'd2);
    hb_wr(32'h20, 8'hB0);
    for (int k = 0; k < 5; k++) rsp_src.push_back(8'hE0 + 8'(k));
    hw_wr(OFS_START, 32'h1);
    wait_done("R9 edge run");
    chk("R4 limit accepted", err_o, 0);
    chk("R11 held size write had no effect", cmd_got.size(), 4);
    chk("R6 new cmd byte", cmd_got[0], 8'hB0);
    exp_mem[DEPTH-2] = 8'hE0; exp_mem[DEPTH-1] = 8'hE1;
    chk_mem("R8 truncated response");

    // T4: writing 0 to start
    req_before = req_cnt;
    hw_wr(OFS_START, 32'h0);
    repeat (3) @(negedge clk);
    chk("R3 zero write start", start_o, 0);
    chk("R3 zero write request", req_cnt, req_before);

    // T5..T7: refused regions
    hb_wr(32'h40, 8'h99); exp_mem[32'h40] = 8'h99;
    @(negedge clk);
    hw_wr(OFS_CMD_ADDR, BASE + 32'hF81); hw_wr(OFS_CMD_SIZE, 32'd0);
    hw_wr(OFS_START, 32'h1);
    wait_done("R5 offset refuse");
    chk("R4 offset past limit", err_o, 1);
    chk("R5 no request", req_cnt, req_before);
    chk_mem("R5 buffer untouched");

    hw_wr(OFS_CMD_ADDR, BASE + 32'hF00); hw_wr(OFS_CMD_SIZE, 32'h81);
    hw_wr(OFS_START, 32'h1);
    wait_done("R5 span refuse");
    chk("R4 span past limit", err_o, 1);
    chk("R5 start cleared", start_o, 0);

    hw_wr(OFS_CMD_ADDR, BASE + 32'h20); hw_wr(OFS_CMD_SIZE, 32'd4);
    hw_wr(OFS_RSP_ADDR, BASE - 32'h1); hw_wr(OFS_RSP_SIZE, 32'd0);
    hw_wr(OFS_START, 32'h1);
    wait_done("R5 wrap refuse");
    chk("R4 address below base", err_o, 1);
    chk("R5 still no request", req_cnt, req_before);

    // T8: empty command at the limit offset, error cleared
    eng_clear(); clear_exp();
    hw_wr(OFS_CMD_ADDR, BASE + 32'hF80); hw_wr(OFS_CMD_SIZE, 32'd0);
    hw_wr(OFS_RSP_ADDR, BASE + 32'h10); hw_wr(OFS_RSP_SIZE, 32'd1);
    rsp_src.push_back(8'hF5);
    hw_wr(OFS_START, 32'h1);
    chk("R5 err cleared by start", err_o, 0);
    wait_done("R9 empty run");
    chk("R2 request issued", req_cnt, req_before + 1);
    chk("R6 no cmd bytes", cmd_got.size(), 0);
    exp_mem[32'h10] = 8'hF5;
    chk_mem("R7 stale byte scrubbed");

    finish_up();
  end
endmodule